// File: doc/BRIEF.md
# Debug Command Access Controller

This block sits between the decoder of a serial debug link and the machinery that carries out debug commands. For each decoded command it decides whether the command may run. The decision takes into account the device security state, whether debug is enabled, whether the core is halted in background mode, whether a flash mass erase is in progress, and where the command falls in a streaming memory sequence. A command that is turned away has one side effect: it raises a sticky illegal-command flag. If it was a read, it also returns a fixed filler byte in every data byte.

The block also keeps the debug state that governs these decisions. This covers the unsecure status, which is loaded at reset and set by a successful mass erase. It covers the debug enable bit, which only a control/status write changes. It covers background mode, which is entered from a command, a CPU halt instruction or a breakpoint, and left by GO. It also covers the mass-erase busy state. After reset the block accepts nothing until a fixed warm-up has passed. While the nonvolatile memory is still initialising, it accepts only always-available commands.

Top module: `dbg_access_ctrl`

## Requirements
- R1: Under reset, `unsec` takes the inverse of `secure_boot`, `dbg_enabled` and `bdm_active` both take `strap_special`, and `illegal_flag` and `erase_busy` are 0.
- R2: `cmd_ready` stays 0 for the first READY_DELAY (10) clock cycles after `rst_n` deasserts. From the 11th cycle on, a command can be accepted.
- R3: While `nvm_busy` is 1, `cmd_ready` is 1 only for commands with `cmd_always` = 1. A command that is not ready is neither executed nor rejected.
- R4: An accepted command with `cmd_impl` = 0 is rejected (`cmd_reject` = 1, `cmd_exec` = 0).
- R5: An accepted command with `cmd_always` = 0 is rejected while `unsec` = 0, while `dbg_enabled` = 0, or while `erase_busy` = 1.
- R6: An accepted command with `cmd_bdm_only` = 1 is rejected while `bdm_active` = 0.
- R7: Kind codes are: 0 other, 1 control/status write, 2 background, 3 GO, 4 mass erase, 5 read memory, 6 write memory, 7 dump, 8 fill, 9 read-same. Dump is legal only right after an executed read memory or dump. Read-same is legal only right after an executed read memory or read-same. Fill is legal only right after an executed write memory or fill. Any other executed command breaks the sequence. Rejected commands leave it unchanged.
- R8: A rejected command with `cmd_is_read` = 1 drives `rsp_rdata` to 0xEE in every byte. In every other cycle `rsp_rdata` equals `mem_rdata`.
- R9: A rejected command sets `illegal_flag` on the next cycle. The flag stays set until an executed control/status write with `cmd_wr_clrflag` = 1 clears it. A rejected command changes no other state.
- R10: An executed control/status write loads `cmd_wr_enable` into `dbg_enabled` on the next cycle.
- R11: While `dbg_enabled` = 1, an executed background command, a `cpu_halt` pulse or a `brkpt` pulse sets `bdm_active` on the next cycle. Otherwise an executed GO clears it. Entry takes priority over GO.
- R12: An executed mass erase sets `erase_busy`. An `erase_done` pulse while busy clears it. If `erase_ok` is 1 it also sets `unsec`; if `erase_ok` is 0, `unsec` is left as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| secure_boot | input | 1 | Security state of the device, sampled during reset |
| strap_special | input | 1 | Special single-chip strap, sampled during reset |
| nvm_busy | input | 1 | Nonvolatile memory initialisation still running |
| cmd_valid | input | 1 | A decoded command is present |
| cmd_kind | input | 4 | Command kind code (see R7) |
| cmd_impl | input | 1 | Opcode is implemented |
| cmd_always | input | 1 | Command is always-available |
| cmd_bdm_only | input | 1 | Command needs active background mode |
| cmd_is_read | input | 1 | Command returns data |
| cmd_wr_enable | input | 1 | Enable value carried by a control/status write |
| cmd_wr_clrflag | input | 1 | Write-one-to-clear for the illegal flag |
| mem_rdata | input | 32 | Read data from the access engine |
| erase_done | input | 1 | Mass erase finished (pulse) |
| erase_ok | input | 1 | Mass erase result, valid with erase_done |
| cpu_halt | input | 1 | CPU halt instruction executed (pulse) |
| brkpt | input | 1 | Breakpoint event (pulse) |
| cmd_ready | output | 1 | Command may be taken this cycle |
| cmd_exec | output | 1 | Command accepted and legal |
| cmd_reject | output | 1 | Command accepted and illegal |
| rsp_rdata | output | 32 | Response read data, filler when a read is rejected |
| illegal_flag | output | 1 | Sticky illegal-command flag |
| unsec | output | 1 | Device unsecured |
| dbg_enabled | output | 1 | Debug enabled |
| bdm_active | output | 1 | Background mode active |
| erase_busy | output | 1 | Mass erase in progress |

## Verification
The hardest state to reach is a streaming command that arrives on an unsecured, enabled, halted device. Only there does the sequence rule alone decide the outcome. Reaching it takes a mass erase that first fails and then succeeds, then a control/status write and a background command, and only then interleaved base, streaming and unrelated commands. A second reset with the special strap and nonvolatile initialisation still running covers the hold-off of non-always commands while always-available ones go through.

// File: rtl/dbg_access_pkg.sv
// Shared types of the debug command access controller.
// Assumes the command decoder presents one of the kind codes below.
package dbg_access_pkg;

    localparam int KIND_W = 4;

    typedef enum logic [KIND_W-1:0] {
        K_OTHER   = 4'd0,
        K_WR_CSR  = 4'd1,
        K_BGND    = 4'd2,
        K_GO      = 4'd3,
        K_ERASE   = 4'd4,
        K_RD_MEM  = 4'd5,
        K_WR_MEM  = 4'd6,
        K_DUMP    = 4'd7,
        K_FILL    = 4'd8,
        K_RD_SAME = 4'd9
    } cmd_kind_e;

    typedef enum logic [2:0] {
        SEQ_NONE,
        SEQ_RD,
        SEQ_DUMP,
        SEQ_WR,
        SEQ_RSAME
    } seq_e;

    typedef struct packed {
        logic impl;
        logic always_ok;
        logic bdm_only;
        logic is_read;
    } cmd_tags_t;

endpackage

// File: rtl/dbg_ready_timer.sv
// Warm-up timer: flags when DELAY cycles have passed since reset released.
// Assumes synchronous active-low reset; saturates once the delay is reached.
module dbg_ready_timer #(
    parameter int DELAY = 10
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);
    localparam int CNT_W = $clog2(DELAY + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DELAY);

    logic [CNT_W-1:0] cnt_q;

    // Count up from reset release and hold at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_q != LIMIT)
            cnt_q <= cnt_q + 1'b1;
    end

    assign done = (cnt_q == LIMIT);
endmodule

// File: rtl/dbg_seq_tracker.sv
// Remembers which streaming memory sequence the last executed command opened.
// Assumes only executed commands move it; rejected ones leave it unchanged.
module dbg_seq_tracker
    import dbg_access_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      exec,
    input  cmd_kind_e kind,
    output seq_e      seq
);
    seq_e seq_q;

    // Advance on each executed command; every other kind closes the sequence.
    always_ff @(posedge clk) begin
        if (!rst_n)
            seq_q <= SEQ_NONE;
        else if (exec) begin
            case (kind)
                K_RD_MEM:  seq_q <= SEQ_RD;
                K_DUMP:    seq_q <= SEQ_DUMP;
                K_RD_SAME: seq_q <= SEQ_RSAME;
                K_WR_MEM,
                K_FILL:    seq_q <= SEQ_WR;
                default:   seq_q <= SEQ_NONE;
            endcase
        end
    end

    assign seq = seq_q;
endmodule

// File: rtl/dbg_legality.sv
// Combinational legality check of one command against the current debug state.
// Assumes tags come from the decoder; all reasons combine with a plain OR.
module dbg_legality
    import dbg_access_pkg::*;
(
    input  cmd_kind_e kind,
    input  cmd_tags_t tags,
    input  logic      unsec,
    input  logic      enabled,
    input  logic      bdm_active,
    input  logic      erase_busy,
    input  seq_e      seq,
    output logic      legal
);
    logic gate_bad;
    logic mode_bad;
    logic seq_bad;

    // Security, enable and erase gate non-always commands.
    always_comb begin
        gate_bad = !tags.always_ok && (!unsec || !enabled || erase_busy);
        mode_bad = tags.bdm_only && !bdm_active;
    end

    // Streaming commands must follow their own base or themselves.
    always_comb begin
        case (kind)
            K_DUMP:    seq_bad = !(seq == SEQ_RD || seq == SEQ_DUMP);
            K_RD_SAME: seq_bad = !(seq == SEQ_RD || seq == SEQ_RSAME);
            K_FILL:    seq_bad = (seq != SEQ_WR);
            default:   seq_bad = 1'b0;
        endcase
    end

    assign legal = tags.impl && !gate_bad && !mode_bad && !seq_bad;
endmodule

// File: rtl/dbg_state_regs.sv
// Debug state registers: unsecure, enable, background mode, erase busy, flag.
// Assumes exec and reject are never both high; sync active-low reset.
module dbg_state_regs
    import dbg_access_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      secure_boot,
    input  logic      strap_special,
    input  logic      exec,
    input  logic      reject,
    input  cmd_kind_e kind,
    input  logic      wr_enable,
    input  logic      wr_clrflag,
    input  logic      erase_done,
    input  logic      erase_ok,
    input  logic      cpu_halt,
    input  logic      brkpt,
    output logic      unsec,
    output logic      enabled,
    output logic      bdm_active,
    output logic      erase_busy,
    output logic      illegal_flag
);
    logic csr_wr;
    logic bdm_enter;

    assign csr_wr    = exec && (kind == K_WR_CSR);
    assign bdm_enter = enabled && ((exec && kind == K_BGND) || cpu_halt || brkpt);

    // Unsecure status: loaded from the boot state, set by a good mass erase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            unsec <= !secure_boot;
        else if (erase_busy && erase_done && erase_ok)
            unsec <= 1'b1;
    end

    // Debug enable: only a control/status write changes it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            enabled <= strap_special;
        else if (csr_wr)
            enabled <= wr_enable;
    end

    // Background mode: entry triggers win over a GO in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bdm_active <= strap_special;
        else if (bdm_enter)
            bdm_active <= 1'b1;
        else if (exec && kind == K_GO)
            bdm_active <= 1'b0;
    end

    // Mass erase busy: set by the erase command, cleared on completion.
    always_ff @(posedge clk) begin
        if (!rst_n)
            erase_busy <= 1'b0;
        else if (exec && kind == K_ERASE)
            erase_busy <= 1'b1;
        else if (erase_done)
            erase_busy <= 1'b0;
    end

    // Sticky illegal flag: set on reject, cleared by write-one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            illegal_flag <= 1'b0;
        else if (reject)
            illegal_flag <= 1'b1;
        else if (csr_wr && wr_clrflag)
            illegal_flag <= 1'b0;
    end
endmodule

// File: rtl/dbg_access_ctrl.sv
// Top of the debug command access controller: accepts, executes or rejects
// each decoded debug command and substitutes filler data on rejected reads.
// Assumes one command per cycle held until cmd_ready; sync active-low reset.
module dbg_access_ctrl
    import dbg_access_pkg::*;
#(
    parameter int         READY_DELAY = 10,
    parameter int         DATA_BYTES  = 4,
    parameter logic [7:0] FILLER      = 8'hEE
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    secure_boot,
    input  logic                    strap_special,
    input  logic                    nvm_busy,
    input  logic                    cmd_valid,
    input  logic [3:0]              cmd_kind,
    input  logic                    cmd_impl,
    input  logic                    cmd_always,
    input  logic                    cmd_bdm_only,
    input  logic                    cmd_is_read,
    input  logic                    cmd_wr_enable,
    input  logic                    cmd_wr_clrflag,
    input  logic [DATA_BYTES*8-1:0] mem_rdata,
    input  logic                    erase_done,
    input  logic                    erase_ok,
    input  logic                    cpu_halt,
    input  logic                    brkpt,
    output logic                    cmd_ready,
    output logic                    cmd_exec,
    output logic                    cmd_reject,
    output logic [DATA_BYTES*8-1:0] rsp_rdata,
    output logic                    illegal_flag,
    output logic                    unsec,
    output logic                    dbg_enabled,
    output logic                    bdm_active,
    output logic                    erase_busy
);
    cmd_kind_e kind;
    cmd_tags_t tags;
    seq_e      seq;
    logic      warm;
    logic      legal;
    logic      accept;
    logic      subst;

    assign kind = cmd_kind_e'(cmd_kind);
    assign tags = '{impl: cmd_impl, always_ok: cmd_always,
                    bdm_only: cmd_bdm_only, is_read: cmd_is_read};

    dbg_ready_timer #(.DELAY(READY_DELAY)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .done (warm)
    );

    dbg_seq_tracker u_seq (
        .clk  (clk),
        .rst_n(rst_n),
        .exec (cmd_exec),
        .kind (kind),
        .seq  (seq)
    );

    dbg_legality u_legal (
        .kind      (kind),
        .tags      (tags),
        .unsec     (unsec),
        .enabled   (dbg_enabled),
        .bdm_active(bdm_active),
        .erase_busy(erase_busy),
        .seq       (seq),
        .legal     (legal)
    );

    dbg_state_regs u_state (
        .clk          (clk),
        .rst_n        (rst_n),
        .secure_boot  (secure_boot),
        .strap_special(strap_special),
        .exec         (cmd_exec),
        .reject       (cmd_reject),
        .kind         (kind),
        .wr_enable    (cmd_wr_enable),
        .wr_clrflag   (cmd_wr_clrflag),
        .erase_done   (erase_done),
        .erase_ok     (erase_ok),
        .cpu_halt     (cpu_halt),
        .brkpt        (brkpt),
        .unsec        (unsec),
        .enabled      (dbg_enabled),
        .bdm_active   (bdm_active),
        .erase_busy   (erase_busy),
        .illegal_flag (illegal_flag)
    );

    // Readiness: warm-up over, and memory init only blocks non-always commands.
    always_comb begin
        cmd_ready = warm && (!nvm_busy || tags.always_ok);
        accept    = cmd_valid && cmd_ready;
        cmd_exec  = accept && legal;
        cmd_reject = accept && !legal;
        subst     = cmd_reject && tags.is_read;
    end

    // Per-byte response mux: filler replaces every byte of a rejected read.
    for (genvar b = 0; b < DATA_BYTES; b++) begin : g_byte
        assign rsp_rdata[b*8 +: 8] = subst ? FILLER : mem_rdata[b*8 +: 8];
    end
endmodule

// File: rtl/dbg_access_chk.sv
// Assertion checker for the debug command access controller, bound to the top.
// Assumes reset is held for at least two cycles before it is released.
module dbg_access_chk #(
    parameter int READY_DELAY = 10,
    parameter int DATA_BYTES  = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cmd_valid,
    input logic                    cmd_always,
    input logic                    cmd_is_read,
    input logic                    cmd_ready,
    input logic                    cmd_exec,
    input logic                    cmd_reject,
    input logic [DATA_BYTES*8-1:0] rsp_rdata,
    input logic                    erase_done,
    input logic                    erase_ok,
    input logic                    illegal_flag,
    input logic                    unsec,
    input logic                    dbg_enabled,
    input logic                    bdm_active
);
    localparam int CW = $clog2(READY_DELAY + 2);
    logic [CW-1:0] since_q;

    // Independent count of cycles since reset release, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_q <= '0;
        else if (since_q <= CW'(READY_DELAY))
            since_q <= since_q + 1'b1;
    end

    assert_warmup_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q < CW'(READY_DELAY)) |-> !cmd_ready);

    assert_outcome_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_exec || cmd_reject) |-> (cmd_valid && cmd_ready && !(cmd_exec && cmd_reject)));

    assert_secure_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && !cmd_always && !unsec) |-> cmd_reject);

    assert_filler_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_reject && cmd_is_read) |-> (rsp_rdata == {DATA_BYTES{8'hEE}}));

    assert_flag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reject |=> illegal_flag);

    assert_reject_no_enable_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reject |=> $stable(dbg_enabled));

    assert_bdm_needs_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bdm_active) |-> $past(dbg_enabled));

    assert_unsec_by_erase_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unsec) |-> $past(erase_done && erase_ok));
endmodule

bind dbg_access_ctrl dbg_access_chk #(
    .READY_DELAY(READY_DELAY),
    .DATA_BYTES (DATA_BYTES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_always  (cmd_always),
    .cmd_is_read (cmd_is_read),
    .cmd_ready   (cmd_ready),
    .cmd_exec    (cmd_exec),
    .cmd_reject  (cmd_reject),
    .rsp_rdata   (rsp_rdata),
    .erase_done  (erase_done),
    .erase_ok    (erase_ok),
    .illegal_flag(illegal_flag),
    .unsec       (unsec),
    .dbg_enabled (dbg_enabled),
    .bdm_active  (bdm_active)
);

// File: tb/test_dbg_access_ctrl.sv
// Bench: behavioural reference model compared with every output each clock.
module test_dbg_access_ctrl;
    logic clk = 0;
    always #5 clk = ~clk;

    logic rst_n = 0, secure_boot = 1, strap_special = 0, nvm_busy = 0;
    logic cmd_valid = 0, cmd_impl = 1, cmd_always = 0, cmd_bdm_only = 0;
    logic cmd_is_read = 0, cmd_wr_enable = 0, cmd_wr_clrflag = 0;
    logic [3:0] cmd_kind = 0;
    logic [31:0] mem_rdata = 0;
    logic erase_done = 0, erase_ok = 0, cpu_halt = 0, brkpt = 0;
    logic cmd_ready, cmd_exec, cmd_reject, illegal_flag, unsec;
    logic dbg_enabled, bdm_active, erase_busy;
    logic [31:0] rsp_rdata;

    dbg_access_ctrl i_dbg_access_ctrl (.*);

    int vectors = 0, errors = 0;
    // Reference model state.
    int m_cnt = 0;
    bit m_unsec, m_en, m_bdm, m_busy, m_flag;
    string m_seq = "none";
    bit e_ready, e_exec, e_rej;
    string why;

    task automatic chk(input string tag, input string name, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h at %0t", tag, name, act, exp, $time);
        end
    endtask

    // Reference decision for the present inputs.
    task automatic model_comb();
        bit ok;
        e_ready = (m_cnt >= 10) && (!nvm_busy || cmd_always);
        ok = 1; why = "R10";
        if (cmd_kind == 7 && !(m_seq == "rd" || m_seq == "dump")) begin ok = 0; why = "R7"; end
        if (cmd_kind == 9 && !(m_seq == "rd" || m_seq == "rsame")) begin ok = 0; why = "R7"; end
        if (cmd_kind == 8 && m_seq != "wr") begin ok = 0; why = "R7"; end
        if (cmd_bdm_only && !m_bdm) begin ok = 0; why = "R6"; end
        if (!cmd_always && (!m_unsec || !m_en || m_busy)) begin ok = 0; why = "R5"; end
        if (!cmd_impl) begin ok = 0; why = "R4"; end
        e_exec = cmd_valid && e_ready && ok;
        e_rej  = cmd_valid && e_ready && !ok;
    endtask

    // Reference state update at a clock edge.
    task automatic model_edge();
        if (!rst_n) begin
            m_cnt = 0; m_unsec = !secure_boot; m_en = strap_special;
            m_bdm = strap_special; m_busy = 0; m_flag = 0; m_seq = "none";
            return;
        end
        if (m_cnt < 10) m_cnt++;
        if (m_busy && erase_done && erase_ok) m_unsec = 1;
        if (m_en && ((e_exec && cmd_kind == 2) || cpu_halt || brkpt)) m_bdm = 1;
        else if (e_exec && cmd_kind == 3) m_bdm = 0;
        if (e_exec && cmd_kind == 4) m_busy = 1;
        else if (erase_done) m_busy = 0;
        if (e_rej) m_flag = 1;
        else if (e_exec && cmd_kind == 1 && cmd_wr_clrflag) m_flag = 0;
        if (e_exec && cmd_kind == 1) m_en = cmd_wr_enable;
        if (e_exec) begin
            case (cmd_kind)
                5: m_seq = "rd";  7: m_seq = "dump"; 9: m_seq = "rsame";
                6, 8: m_seq = "wr"; default: m_seq = "none";
            endcase
        end
    endtask

    // One cycle: compare shortly after the falling edge, then step the model.
    task automatic tick();
        string st;
        #1;
        model_comb();
        st = (!rst_n || m_cnt == 0) ? "R1" : "R12";
        chk(m_cnt < 10 ? "R2" : "R3", "cmd_ready", cmd_ready, e_ready);
        chk(why, "cmd_exec", cmd_exec, e_exec);
        chk(why, "cmd_reject", cmd_reject, e_rej);
        chk("R8", "rsp_rdata", rsp_rdata, (e_rej && cmd_is_read) ? 32'hEEEEEEEE : mem_rdata);
        chk(st == "R1" ? "R1" : "R9", "illegal_flag", illegal_flag, m_flag);
        chk(st, "unsec", unsec, m_unsec);
        chk(st == "R1" ? "R1" : "R10", "dbg_enabled", dbg_enabled, m_en);
        chk(st == "R1" ? "R1" : "R11", "bdm_active", bdm_active, m_bdm);
        chk(st, "erase_busy", erase_busy, m_busy);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        cmd_valid = 0; erase_done = 0; erase_ok = 0; cpu_halt = 0; brkpt = 0;
        mem_rdata = mem_rdata * 32'd1103515245 + 32'd12345;
    endtask

    // Issue one command: kind, implemented, always-available, bdm-only, read.
    task automatic cmd(input int k, input bit impl, input bit alw, input bit bo, input bit rd,
                       input bit wen = 0, input bit wclr = 0);
        cmd_valid = 1; cmd_kind = 4'(k); cmd_impl = impl; cmd_always = alw;
        cmd_bdm_only = bo; cmd_is_read = rd; cmd_wr_enable = wen; cmd_wr_clrflag = wclr;
        tick();
    endtask

    task automatic do_reset(input bit sec, input bit strap);
        rst_n = 0; secure_boot = sec; strap_special = strap;
        repeat (3) tick();
        rst_n = 1;
    endtask

    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        @(posedge clk); @(posedge clk); model_edge(); @(negedge clk);
        // R1 reset state secure, R2 warm-up with a waiting command.
        do_reset(1, 0);
        repeat (10) cmd(5, 1, 0, 0, 1);
        // R5 secure rejects memory read with filler (R8), flag set (R9).
        cmd(5, 1, 0, 0, 1);
        cmd(1, 1, 1, 0, 1, 1, 0);           // R10 enable
        cmd(5, 1, 0, 0, 1);                 // still secure
        cmd(1, 1, 1, 0, 0, 1, 1);           // R9 clear flag
        // R12 erase that fails, then one that succeeds.
        cmd(4, 1, 1, 0, 0);
        cmd(5, 1, 0, 0, 1);
        cmd(0, 1, 1, 0, 1);
        erase_done = 1; erase_ok = 0; tick();
        tick();
        cmd(4, 1, 1, 0, 0);
        erase_done = 1; erase_ok = 1; tick();
        tick();
        // R6 GO without background, then R11 BACKGROUND.
        cmd(3, 1, 0, 1, 0);
        cmd(2, 1, 0, 0, 0);
        // R7 sequences.
        cmd(7, 1, 0, 1, 1);                 // dump without base
        cmd(5, 1, 0, 1, 1); cmd(7, 1, 0, 1, 1); cmd(7, 1, 0, 1, 1);
        cmd(9, 1, 0, 1, 1);                 // read-same after dump
        cmd(6, 1, 0, 1, 0); cmd(8, 1, 0, 1, 0); cmd(8, 1, 0, 1, 0);
        cmd(7, 1, 0, 1, 1);                 // dump in fill sequence
        cmd(8, 1, 0, 1, 0);                 // rejected: fill sequence kept
        cmd(0, 1, 0, 0, 0); cmd(8, 1, 0, 1, 0);
        cmd(5, 1, 0, 1, 1); cmd(9, 1, 0, 1, 1); cmd(9, 1, 0, 1, 1);
        cmd(12, 0, 0, 0, 1);                // R4 unimplemented
        // R11 triggers and GO.
        cmd(3, 1, 0, 1, 0);
        cpu_halt = 1; tick();
        cmd(3, 1, 0, 1, 0);
        brkpt = 1; tick();
        cpu_halt = 1; cmd(3, 1, 0, 1, 0);   // entry beats GO
        cmd(3, 1, 0, 1, 0);
        cmd(1, 1, 1, 0, 0, 0, 1);           // disable
        cpu_halt = 1; tick();
        brkpt = 1; cmd(2, 1, 0, 0, 0);      // disabled: rejected, no entry
        // R3 special reset, memory init running.
        do_reset(0, 1);
        nvm_busy = 1;
        repeat (10) tick();
        cmd(5, 1, 0, 1, 1);
        cmd(1, 1, 1, 0, 1, 1, 0);
        nvm_busy = 0;
        cmd(5, 1, 0, 1, 1); cmd(7, 1, 0, 1, 1);
        cmd(3, 1, 0, 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule